// File: doc/BRIEF.md
# Stop Mode Selection Controller

This block records which low-power stop mode the system takes when the processor signals a deep sleep. Software programs it through a small register port. A write-once permission register decides which of the deeper modes may be selected. A three-bit mode-select register holds the primary stop mode. A stop-control register refines that choice: a partial-stop option applies to normal stop, and a sub-mode selector applies to very-low-leakage stop.

A sleep request counts only while the deep-sleep flag is high. On such a request the block decodes the current settings into a registered one-hot mode-entry vector, which the power sequencer downstream acts on. The vector holds until a wakeup input clears it. A reserved, malformed or unpermitted selection still enters normal stop, and in that case the block raises a single-cycle error pulse.

Two resets drive the block. The power-on reset clears everything. The system reset clears everything except the stop-control register, which keeps its value.

Top module: `stop_mode_ctrl`

## Requirements
- R1: After a power-on reset, the registers read as follows: permission (address 0) reads 0x00, mode select (address 1) reads 0x00 and stop control (address 2) reads 0x03. Address 3 reads 0x00. `modeEntry` is 0 and `modeErr` is 0.
- R2: Permission bit 0 enables very-low-power stop, bit 1 enables low-leakage stop and bit 2 enables very-low-leakage stop. The register accepts only the first write after any reset. Later writes leave the readback unchanged.
- R3: A write of code 010, 011 or 100 to mode select takes effect only when the matching permission bit is set. Otherwise the previous value stays. Codes 000, 001, 101, 110 and 111 are always stored.
- R4: In stop control, bits 7:6 (partial-stop option) and bits 2:0 (sub-mode) store the written value. Bits 5:3 always read as zero.
- R5: A system reset clears the permission and mode-select registers but leaves stop control unchanged. Only a power-on reset returns stop control to 0x03.
- R6: Mode entry happens only when `sleepReq` is high and `deepSleep` is high in the same cycle. `sleepReq` without `deepSleep` leaves `modeEntry` at 0.
- R7: One cycle after a qualifying request, `modeEntry` is one-hot. Code 000 selects bit 0 (stop), 010 selects bit 3 (very-low-power stop), 011 selects bit 4 (low-leakage stop) and 100 selects bit 5+k (very-low-leakage sub-mode k).
- R8: With code 000, a partial-stop option of 01 selects bit 1 and 10 selects bit 2 instead of bit 0.
- R9: With code 100, sub-mode values 0 to 3 select bits 5 to 8 respectively.
- R10: A reserved code (001, 101, 110, 111), a partial-stop option of 11, a sub-mode of 4 to 7, or an unpermitted code makes `modeErr` high for exactly one cycle with `modeEntry` equal to bit 0.
- R11: `modeEntry` holds its value, and ignores further sleep requests, until `wakeup` is high. One cycle after `wakeup`, `modeEntry` is 0. `wakeup` takes priority over a simultaneous request.
- R12: `modeEntry` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| sysRstN | input | 1 | System reset, active low, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| sleepReq | input | 1 | Sleep-now or sleep-on-exit request |
| deepSleep | input | 1 | Deep-sleep flag from the processor |
| wakeup | input | 1 | Wakeup event; clears the mode-entry vector |
| modeEntry | output | 9 | Registered one-hot selected stop mode |
| modeErr | output | 1 | One-cycle pulse on a reserved or forbidden selection |

## Verification
The hardest state to reach is a given mode code combined with a given permission mask. Each permission mask can be written only once per reset, so the bench applies a system reset before every mask. It then walks all eight codes under that mask, rewriting code 000 before each attempt so that a blocked write shows up as 000 at readback. Each attempt is followed by a full sleep, hold and wakeup cycle. A second sweep varies the partial-stop option and the sub-mode under the full mask, which reaches every error path and every one-hot bit.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam logic [2:0] CODE_STOP = 3'b000;
  localparam logic [2:0] CODE_VLPS = 3'b010;
  localparam logic [2:0] CODE_LLS  = 3'b011;
  localparam logic [2:0] CODE_VLLS = 3'b100;

  localparam int IDX_STOP   = 0;
  localparam int IDX_PSTOP1 = 1;
  localparam int IDX_PSTOP2 = 2;
  localparam int IDX_VLPS   = 3;
  localparam int IDX_LLS    = 4;
  localparam int IDX_VLLS0  = 5;

  typedef enum logic {ST_RUN, ST_STOPPED} pwrState_t;

  typedef struct packed {
    logic wrProt;
    logic wrMode;
    logic wrStop;
    logic enter;
    logic leave;
  } ctrlStrobes_t;
endpackage

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int ADDR_PROT = 0,
  parameter int ADDR_MODE = 1,
  parameter int ADDR_STOP = 2
) (
  input  logic              clk,
  input  logic              anyRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              sleepReq,
  input  logic              deepSleep,
  input  logic              wakeup,
  output ctrlStrobes_t      strb
);
  pwrState_t state, stateNxt;
  logic qualReq;

  assign qualReq = sleepReq & deepSleep;

  always_comb begin
    stateNxt = state;
    strb = '0;
    strb.wrProt = regWrEn && (regAddr == ADDR_W'(ADDR_PROT));
    strb.wrMode = regWrEn && (regAddr == ADDR_W'(ADDR_MODE));
    strb.wrStop = regWrEn && (regAddr == ADDR_W'(ADDR_STOP));
    case (state)
      ST_RUN: begin
        if (wakeup) begin
          strb.leave = 1'b1;
        end else if (qualReq) begin
          strb.enter = 1'b1;
          stateNxt = ST_STOPPED;
        end
      end
      ST_STOPPED: begin
        if (wakeup) begin
          strb.leave = 1'b1;
          stateNxt = ST_RUN;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) state <= ST_RUN;
    else          state <= stateNxt;
  end
endmodule

// File: rtl/smc_datapath.sv
module smc_datapath
  import smc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int ADDR_PROT = 0,
  parameter int ADDR_MODE = 1,
  parameter int ADDR_STOP = 2,
  parameter int CODE_W    = 3,
  parameter int PROT_W    = 3,
  parameter int PSTOP_W   = 2,
  parameter int SUB_W     = 3,
  parameter int NUM_VLLS  = 4,
  parameter int SUB_RESET = 3,
  parameter int NUM_MODES = IDX_VLLS0 + NUM_VLLS
) (
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 anyRstN,
  input  ctrlStrobes_t         strb,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic [NUM_MODES-1:0] modeEntry,
  output logic                 modeErr
);
  localparam int GAP_W = DATA_W - PSTOP_W - SUB_W;

  logic [PROT_W-1:0]  protBits;
  logic               protLocked;
  logic [CODE_W-1:0]  modeCode;
  logic [PSTOP_W-1:0] pstopSel;
  logic [SUB_W-1:0]   subSel;
  logic [CODE_W-1:0]  wrCode;
  logic               wrAllowed;
  logic [NUM_VLLS-1:0] vllsHit;
  logic [NUM_MODES-1:0] decVec;
  logic               decErr;

  // Permission needed for a given code
  function automatic logic codePermitted(input logic [CODE_W-1:0] c,
                                         input logic [PROT_W-1:0] p);
    case (c)
      CODE_VLPS: return p[0];
      CODE_LLS:  return p[1];
      CODE_VLLS: return p[2];
      default:   return 1'b1;
    endcase
  endfunction

  assign wrCode    = regWrData[CODE_W-1:0];
  assign wrAllowed = codePermitted(wrCode, protBits);

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      protBits   <= '0;
      protLocked <= 1'b0;
    end else if (strb.wrProt && !protLocked) begin
      protBits   <= regWrData[PROT_W-1:0];
      protLocked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN)                       modeCode <= CODE_STOP;
    else if (strb.wrMode && wrAllowed)  modeCode <= wrCode;
  end

  // Stop control survives system reset; only power-on clears it
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pstopSel <= '0;
      subSel   <= SUB_W'(SUB_RESET);
    end else if (strb.wrStop) begin
      pstopSel <= regWrData[DATA_W-1 -: PSTOP_W];
      subSel   <= regWrData[SUB_W-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_PROT))      regRdData[PROT_W-1:0] = protBits;
    else if (regAddr == ADDR_W'(ADDR_MODE)) regRdData[CODE_W-1:0] = modeCode;
    else if (regAddr == ADDR_W'(ADDR_STOP)) regRdData = {pstopSel, {GAP_W{1'b0}}, subSel};
  end

  generate
    for (genvar k = 0; k < NUM_VLLS; k++) begin : g_vlls
      assign vllsHit[k] = (subSel == SUB_W'(k));
    end
  endgenerate

  always_comb begin
    decVec = '0;
    decErr = 1'b0;
    case (modeCode)
      CODE_STOP: begin
        case (pstopSel)
          2'd0:    decVec[IDX_STOP]   = 1'b1;
          2'd1:    decVec[IDX_PSTOP1] = 1'b1;
          2'd2:    decVec[IDX_PSTOP2] = 1'b1;
          default: decErr = 1'b1;
        endcase
      end
      CODE_VLPS: begin
        if (protBits[0]) decVec[IDX_VLPS] = 1'b1;
        else             decErr = 1'b1;
      end
      CODE_LLS: begin
        if (protBits[1]) decVec[IDX_LLS] = 1'b1;
        else             decErr = 1'b1;
      end
      CODE_VLLS: begin
        if (protBits[2] && (|vllsHit)) decVec[IDX_VLLS0 +: NUM_VLLS] = vllsHit;
        else                           decErr = 1'b1;
      end
      default: decErr = 1'b1;
    endcase
    if (decErr) begin
      decVec = '0;
      decVec[IDX_STOP] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) begin
      modeEntry <= '0;
      modeErr   <= 1'b0;
    end else begin
      modeErr <= strb.enter & decErr;
      if (strb.leave)      modeEntry <= '0;
      else if (strb.enter) modeEntry <= decVec;
    end
  end
endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
  import smc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int NUM_VLLS  = 4,
  parameter int NUM_MODES = IDX_VLLS0 + NUM_VLLS
) (
  input  logic                 clk,
  input  logic                 porRstN,
  input  logic                 sysRstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 sleepReq,
  input  logic                 deepSleep,
  input  logic                 wakeup,
  output logic [NUM_MODES-1:0] modeEntry,
  output logic                 modeErr
);
  ctrlStrobes_t strb;
  logic anyRstN;

  assign anyRstN = porRstN & sysRstN;

  smc_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .anyRstN(anyRstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .sleepReq(sleepReq), .deepSleep(deepSleep), .wakeup(wakeup), .strb(strb)
  );

  smc_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_VLLS(NUM_VLLS), .NUM_MODES(NUM_MODES)
  ) dp_i (
    .clk(clk), .porRstN(porRstN), .anyRstN(anyRstN), .strb(strb),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .modeEntry(modeEntry), .modeErr(modeErr)
  );
endmodule

// File: rtl/smc_chk.sv
module smc_chk #(
  parameter int NUM_MODES = 9
) (
  input logic                 clk,
  input logic                 porRstN,
  input logic                 sysRstN,
  input logic                 sleepReq,
  input logic                 deepSleep,
  input logic                 wakeup,
  input logic [NUM_MODES-1:0] modeEntry,
  input logic                 modeErr
);
  // R12
  onehot_entry_chk: assert property (@(posedge clk) disable iff (!(porRstN && sysRstN))
    $onehot0(modeEntry));

  // R10
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!(porRstN && sysRstN))
    modeErr |=> !modeErr);

  // R10
  err_fallback_chk: assert property (@(posedge clk) disable iff (!(porRstN && sysRstN))
    modeErr |-> modeEntry[0]);

  // R11
  entry_hold_chk: assert property (@(posedge clk) disable iff (!(porRstN && sysRstN))
    ((|modeEntry) && !wakeup) |=> $stable(modeEntry));

  // R11
  wakeup_clear_chk: assert property (@(posedge clk) disable iff (!(porRstN && sysRstN))
    wakeup |=> (modeEntry == '0));

  // R6
  entry_needs_deep_chk: assert property (@(posedge clk) disable iff (!(porRstN && sysRstN))
    $rose(|modeEntry) |-> $past(sleepReq && deepSleep));
endmodule

bind stop_mode_ctrl smc_chk #(.NUM_MODES(NUM_MODES)) chk_i (
  .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .sleepReq(sleepReq),
  .deepSleep(deepSleep), .wakeup(wakeup), .modeEntry(modeEntry), .modeErr(modeErr)
);

// File: tb/stop_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module stop_mode_ctrl_tb_top;
  localparam int NM = 9;

  logic clk = 1'b0;
  logic porRstN = 1'b0, sysRstN = 1'b1;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic sleepReq = 1'b0, deepSleep = 1'b0, wakeup = 1'b0;
  logic [NM-1:0] modeEntry;
  logic modeErr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stop_mode_ctrl dut_i (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sleepReq(sleepReq), .deepSleep(deepSleep), .wakeup(wakeup),
    .modeEntry(modeEntry), .modeErr(modeErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doPor();
    @(negedge clk); porRstN = 1'b0;
    repeat (2) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doSys();
    @(negedge clk); sysRstN = 1'b0;
    repeat (2) @(negedge clk);
    sysRstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    regAddr = 2'(a);
    #0.5;
    d = int'(regRdData);
  endtask

  function automatic bit permitted(input int c, input int p);
    if (c == 2) return p[0];
    if (c == 3) return p[1];
    if (c == 4) return p[2];
    return 1'b1;
  endfunction

  // expected one-hot index, -1 for an error selection
  function automatic int expIdx(input int c, input int p, input int ps, input int sub);
    if (!permitted(c, p)) return -1;
    case (c)
      0: return (ps < 3) ? ps : -1;
      2: return 3;
      3: return 4;
      4: return (sub < 4) ? 5 + sub : -1;
      default: return -1;
    endcase
  endfunction

  task automatic sleepCycle(input int idx, input string tag);
    int expVec;
    int expErr;
    expVec = (idx < 0) ? 1 : (1 << idx);
    expErr = (idx < 0) ? 1 : 0;
    @(negedge clk); sleepReq = 1'b1; deepSleep = 1'b1;
    @(negedge clk); sleepReq = 1'b0; deepSleep = 1'b0;
    chk(int'(modeEntry) == expVec, tag, int'(modeEntry), expVec);
    chk(int'(modeErr) == expErr, (idx < 0) ? "R10" : tag, int'(modeErr), expErr);
    chk($countones(modeEntry) <= 1, "R12", $countones(modeEntry), 1);
    @(negedge clk);
    chk(modeErr == 1'b0, "R10 pulse", int'(modeErr), 0);
    chk(int'(modeEntry) == expVec, "R11 hold", int'(modeEntry), expVec);
    wakeup = 1'b1;
    @(negedge clk); wakeup = 1'b0;
    chk(modeEntry == '0, "R11 wake", int'(modeEntry), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    doPor();
    // R1 reset state
    rd(0, v); chk(v == 0, "R1 prot", v, 0);
    rd(1, v); chk(v == 0, "R1 mode", v, 0);
    rd(2, v); chk(v == 8'h03, "R1 stop", v, 8'h03);
    rd(3, v); chk(v == 0, "R1 addr3", v, 0);
    chk(modeEntry == '0 && !modeErr, "R1 outputs", int'({modeErr, modeEntry}), 0);

    // R4 stop-control field layout
    wr(2, 8'hFF); rd(2, v); chk(v == 8'hC7, "R4", v, 8'hC7);
    wr(2, 8'h38); rd(2, v); chk(v == 8'h00, "R4", v, 8'h00);

    // R5 reset domains
    wr(0, 5); wr(1, 2); wr(2, 8'h81);
    doSys();
    rd(0, v); chk(v == 0, "R5 prot", v, 0);
    rd(1, v); chk(v == 0, "R5 mode", v, 0);
    rd(2, v); chk(v == 8'h81, "R5 stop kept", v, 8'h81);
    doPor();
    rd(2, v); chk(v == 8'h03, "R5 stop por", v, 8'h03);

    // R6 no entry without deep-sleep flag, nor with the flag alone
    @(negedge clk); sleepReq = 1'b1; deepSleep = 1'b0;
    repeat (2) @(negedge clk);
    chk(modeEntry == '0, "R6 no deep", int'(modeEntry), 0);
    sleepReq = 1'b0; deepSleep = 1'b1;
    repeat (2) @(negedge clk);
    chk(modeEntry == '0, "R6 no req", int'(modeEntry), 0);
    deepSleep = 1'b0;

    // Sweep: permission mask x mode code (R2, R3, R7, R10)
    for (int p = 0; p < 8; p++) begin
      doSys();
      wr(2, 8'h00);
      wr(0, p);
      wr(0, (~p) & 7);
      rd(0, v); chk(v == p, "R2", v, p);
      for (int c = 0; c < 8; c++) begin
        int e, got;
        wr(1, 0);
        wr(1, c);
        e = permitted(c, p) ? c : 0;
        rd(1, got); chk(got == e, "R3", got, e);
        sleepCycle(expIdx(e, p, 0, 0), "R7");
      end
    end

    // Partial-stop sweep (R8) and sub-mode sweep (R9)
    doSys();
    wr(0, 7);
    wr(1, 0);
    for (int ps = 0; ps < 4; ps++) begin
      wr(2, (ps << 6) | 3);
      sleepCycle(expIdx(0, 7, ps, 3), "R8");
    end
    wr(1, 4);
    for (int s = 0; s < 8; s++) begin
      wr(2, s);
      sleepCycle(expIdx(4, 7, 0, s), "R9");
    end

    // R11: requests ignored while held, wakeup priority
    wr(1, 3);
    @(negedge clk); sleepReq = 1'b1; deepSleep = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
    chk(int'(modeEntry) == (1 << 4), "R11 enter", int'(modeEntry), 1 << 4);
    wr(1, 2);
    @(negedge clk); sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(int'(modeEntry) == (1 << 4), "R11 ignore", int'(modeEntry), 1 << 4);
    wakeup = 1'b1;
    @(negedge clk); wakeup = 1'b0;
    chk(modeEntry == '0, "R11 wake", int'(modeEntry), 0);
    sleepReq = 1'b1; wakeup = 1'b1;
    @(negedge clk); sleepReq = 1'b0; wakeup = 1'b0; deepSleep = 1'b0;
    chk(modeEntry == '0, "R11 priority", int'(modeEntry), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule